// File: doc/BRIEF.md
# Time Slot Interchanger

This block is a time switch for one TDM highway of PCM samples. A frame holds `SLOTS` time slots (32 by default), and each slot carries one `W`-bit sample (8 bits by default). One clock cycle is one slot. An internal slot counter runs freely. It steps once per cycle and wraps at the end of the frame. The sample presented on `in_data` in the cycle when the counter is at `i` belongs to input slot `i`, and it is stored at speech-memory location `i`. The first clock edge after reset is released is input slot 0.

Output slot `j` is shown on `out_data` in the cycle after input slot `j`. Its value is the speech-memory location named by connection entry `j`, so the read order is set by the host while the write order is fixed. A mapped sample reaches its output slot either later in the same frame or, when its source slot comes after its output slot, in the next frame. The highway itself is not changed. Only the slot position of each sample moves. A host loads entries through a one-cycle write strobe. Each entry carries a valid bit. Loads are held in a pending copy, and the whole copy goes live at the next frame boundary.

Top module: `tsi`

## Requirements
- R1: During reset and after it, `out_data` is 8'hFF and `out_frame_start` is 0. Every connection entry starts out invalid, and the speech memory is cleared to zero, so the first frame after reset is all 8'hFF.
- R2: `out_frame_start` is 1 exactly in the cycles where `out_data` carries output slot 0. That is the cycle after input slot 0, once every `SLOTS` cycles.
- R3: If output slot j maps to input slot s with s < j, the sample of input slot s appears in output slot j of the same frame, j−s slots later. Input 3 to output 8 gives 5 slots.
- R4: If s > j, output slot j carries the sample that input slot s held in the previous frame, SLOTS−s+j slots later. Input 8 to output 3 gives 27 slots.
- R5: If s == j, the sample entering in that slot is passed out in that same slot, with zero slot delay.
- R6: An output slot whose entry is invalid drives 8'hFF.
- R7: A host write (`cfg_we`=1, entry `cfg_out_slot` set to source `cfg_in_slot` with valid `cfg_valid`) is used from output slot 0 of the next frame. This includes a write made during the last slot of a frame. All remaining slots of the current frame keep the old mapping.
- R8: Writing an entry with `cfg_valid`=0 returns that output slot to 8'hFF from the next frame.
- R9: Several output slots may name the same input slot, and each of them carries a copy of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | W | Sample of the current input slot |
| cfg_we | input | 1 | Connection-entry write strobe |
| cfg_out_slot | input | $clog2(SLOTS) | Output slot whose entry is written |
| cfg_in_slot | input | $clog2(SLOTS) | Source input slot for that entry |
| cfg_valid | input | 1 | Valid bit for that entry |
| out_data | output | W | Sample of the current output slot |
| out_frame_start | output | 1 | High while output slot 0 is shown |

## Verification
The bench covers forward mappings (input 3 to output 8) and backward mappings (input 8 to output 3). A design that ignored frame order would put the wrong frame's sample in the backward case. It also covers the equal-slot case, where a design without a write-through path would output the previous frame's sample instead of the current one. Host writes land in the middle of a frame, in its last slot, and as valid-bit clears. These cases show whether a design splits a frame between two mappings or misses a write made in the final slot. A broadcast mapping and a wrap across output slot 0 and input slot 31 are also included. Together they expose address aliasing and an off-by-one error in the frame marker.

// File: rtl/tsi.sv
module tsi #(
  parameter int SLOTS = 32,
  parameter int W = 8,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  in_data,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_out_slot,
  input  logic [AW-1:0] cfg_in_slot,
  input  logic          cfg_valid,
  output logic [W-1:0]  out_data,
  output logic          out_frame_start
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);
  localparam logic [W-1:0] IDLE = '1;

  logic [AW-1:0] slot_cnt;
  logic [SLOTS-1:0][W-1:0] sm;
  logic [SLOTS-1:0][AW-1:0] act_src, pend_src, pend_src_nxt;
  logic [SLOTS-1:0] act_vld, pend_vld, pend_vld_nxt;
  logic [AW-1:0] rd_addr;
  logic rd_vld;
  logic frame_end;

  assign frame_end = (slot_cnt == LAST);
  assign rd_addr = act_src[slot_cnt];
  assign rd_vld = act_vld[slot_cnt];

  for (genvar g = 0; g < SLOTS; g++) begin : g_pend
    logic hit;
    assign hit = cfg_we && (cfg_out_slot == AW'(g));
    assign pend_src_nxt[g] = hit ? cfg_in_slot : pend_src[g];
    assign pend_vld_nxt[g] = hit ? cfg_valid : pend_vld[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      sm <= '0;
      pend_src <= '0;
      pend_vld <= '0;
      act_src <= '0;
      act_vld <= '0;
      out_data <= IDLE;
      out_frame_start <= 1'b0;
    end else begin
      slot_cnt <= frame_end ? '0 : slot_cnt + 1'b1;
      sm[slot_cnt] <= in_data;
      pend_src <= pend_src_nxt;
      pend_vld <= pend_vld_nxt;
      if (frame_end) begin
        act_src <= pend_src_nxt;
        act_vld <= pend_vld_nxt;
      end
      if (!rd_vld)
        out_data <= IDLE;
      else if (rd_addr == slot_cnt)
        out_data <= in_data;
      else
        out_data <= sm[rd_addr];
      out_frame_start <= (slot_cnt == '0);
    end
  end
endmodule

// File: rtl/tsi_chk.sv
module tsi_chk #(
  parameter int SLOTS = 32,
  parameter int W = 8,
  localparam int AW = $clog2(SLOTS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [W-1:0]              in_data,
  input logic [W-1:0]              out_data,
  input logic                      out_frame_start,
  input logic [AW-1:0]             slot_cnt,
  input logic [SLOTS-1:0]          act_vld,
  input logic [SLOTS-1:0][AW-1:0]  act_src
);
  logic [AW:0] gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
      seen <= 1'b0;
    end else if (out_frame_start) begin
      gap <= '0;
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (out_data == '1 && !out_frame_start));

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_frame_start && seen) |-> (gap == (AW+1)'(SLOTS - 1)));

  // R5
  same_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld[slot_cnt] && act_src[slot_cnt] == slot_cnt) |=> (out_data == $past(in_data)));

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld[slot_cnt] |=> (out_data == '1));

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt != '0) |-> ($stable(act_vld) && $stable(act_src)));
endmodule

bind tsi tsi_chk #(.SLOTS(SLOTS), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_data(out_data),
  .out_frame_start(out_frame_start), .slot_cnt(slot_cnt),
  .act_vld(act_vld), .act_src(act_src)
);

// File: tb/tb_tsi.sv
module tb_tsi;
  localparam int CLK_NS = 10;
  localparam int SLOTS = 32;
  localparam int W = 8;
  localparam int AW = $clog2(SLOTS);

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n;
  logic [W-1:0] in_data;
  logic cfg_we, cfg_valid;
  logic [AW-1:0] cfg_out_slot, cfg_in_slot;
  logic [W-1:0] out_data;
  logic out_frame_start;

  tsi #(.SLOTS(SLOTS), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .cfg_we(cfg_we),
    .cfg_out_slot(cfg_out_slot), .cfg_in_slot(cfg_in_slot), .cfg_valid(cfg_valid),
    .out_data(out_data), .out_frame_start(out_frame_start)
  );

  typedef struct {
    logic [W-1:0] d;
    logic fs;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  int cyc = 0, frame = -1;
  int act_src[SLOTS], pend_src[SLOTS];
  bit act_v[SLOTS], pend_v[SLOTS], cleared[SLOTS];
  logic [W-1:0] cur[SLOTS], prev[SLOTS];

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(bit we, int o, int i, bit v);
    int slot;
    int src;
    int sharers;
    exp_t e;
    slot = cyc % SLOTS;
    if (slot == 0) begin
      frame++;
      for (int k = 0; k < SLOTS; k++) begin
        act_src[k] = pend_src[k];
        act_v[k] = pend_v[k];
        prev[k] = cur[k];
      end
    end
    in_data = 8'({frame[2:0], slot[4:0]}) ^ 8'h21;
    cur[slot] = in_data;
    cfg_we = we;
    cfg_out_slot = AW'(o);
    cfg_in_slot = AW'(i);
    cfg_valid = v;
    if (we) begin
      pend_src[o] = i;
      pend_v[o] = v;
      if (!v) cleared[o] = 1;
    end
    e.fs = (slot == 0);
    if (!act_v[slot]) begin
      e.d = '1;
      e.tag = (frame == 0) ? "R1" : (cleared[slot] ? "R8" : "R6");
    end else begin
      src = act_src[slot];
      e.d = (src <= slot) ? cur[src] : prev[src];
      sharers = 0;
      for (int k = 0; k < SLOTS; k++)
        if (act_v[k] && act_src[k] == src) sharers++;
      if (src == slot) e.tag = "R5";
      else if (sharers > 1) e.tag = "R9";
      else if (src < slot) e.tag = "R3";
      else e.tag = "R4";
    end
    if (pend_v[slot] != act_v[slot] || (act_v[slot] && pend_src[slot] != act_src[slot]))
      e.tag = "R7";
    q.push_back(e);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_NS/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, out_data, e.d);
        check("R2", W'(out_frame_start), W'(e.fs));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) begin
      act_src[k] = 0; pend_src[k] = 0; act_v[k] = 0; pend_v[k] = 0;
      cleared[k] = 0; cur[k] = '0; prev[k] = '0;
    end
    rst_n = 1'b0;
    in_data = '0;
    cfg_we = 0; cfg_valid = 0; cfg_out_slot = '0; cfg_in_slot = '0;
    repeat (3) @(negedge clk);
    check("R1", out_data, 8'hFF);
    check("R1", W'(out_frame_start), W'(0));
    rst_n = 1'b1;
    for (int f = 0; f < 7; f++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (f == 1 && s == 2) step(1, 8, 3, 1);
        else if (f == 1 && s == 3) step(1, 3, 8, 1);
        else if (f == 1 && s == 4) step(1, 5, 5, 1);
        else if (f == 1 && s == 5) step(1, 10, 3, 1);
        else if (f == 1 && s == 6) step(1, 31, 0, 1);
        else if (f == 1 && s == 7) step(1, 0, 31, 1);
        else if (f == 3 && s == 2) step(1, 5, 0, 0);
        else if (f == 3 && s == 31) step(1, 12, 20, 1);
        else if (f == 5 && s == 4) step(1, 8, 9, 1);
        else step(0, 0, 0, 0);
      end
    end
    @(posedge clk);
    #(CLK_NS/2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule